// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block handles one cache miss at a time. It refills a 32-byte cache line from lower-level memory, which returns the line as four 64-bit beats. The processor is released as soon as the word it asked for arrives, without waiting for the whole line. The controller therefore drives two outputs: a word-write port into the cache data array and a forwarding port back to the processor.

Two fill policies are selectable per miss. In wrap mode the memory is asked to start at the missed word, and the beats wrap around the line from there. In linear mode the line is fetched from word 0 upward, and the missed word is forwarded when its beat passes by. Memory beats may be separated by any number of idle cycles. A beat counter tracks progress, and the line is declared complete only with its fourth beat. A new miss is refused while a fill is running.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, busy_o, mem_req_o, arr_we_o, fwd_valid_o and line_done_o are low and miss_ready_o is high.
- R2: When idle, a cycle with miss_valid_i high is accepted in that same cycle. In that cycle mem_req_o is high, mem_line_o carries miss_addr_i[31:5], and mem_first_o carries the word that the memory must send first: miss_addr_i[4:3] when mode_i is 0 (wrap), and 0 when mode_i is 1 (linear). busy_o is high from the next cycle on.
- R3: In wrap mode (mode_i=0), beat k of the fill (k = 0..3) is written to word index (miss_addr_i[4:3] + k) mod 4.
- R4: In linear mode (mode_i=1), beat k of the fill is written to word index k.
- R5: fwd_valid_o is high for exactly one cycle per fill. That cycle is the cycle of the beat that carries the missed word, and fwd_data_o then equals mem_rdata_i.
- R6: line_done_o is high for exactly one cycle per fill, namely the cycle of the fourth beat.
- R7: busy_o stays high through the cycle of the fourth beat and is low in the following cycle. miss_ready_o is the inverse of busy_o.
- R8: miss_valid_i is ignored while busy_o is high. No mem_req_o is raised, and the running fill keeps its word order and its forwarding target.
- R9: Cycles without mem_rvalid_i during a fill do not advance the fill. They cause no write, no forward and no completion.
- R10: mem_rvalid_i while idle is ignored. It causes no write, no forward and no completion, and the next fill still begins with its first beat.
- R11: On each beat during a fill, arr_we_o is high, arr_wdata_o equals mem_rdata_i and arr_line_o equals the line of the accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request |
| miss_addr_i | input | 32 | Byte address of the missed word |
| mode_i | input | 1 | 0 = wrap from missed word, 1 = linear from word 0 |
| miss_ready_o | output | 1 | Controller can accept a miss |
| mem_req_o | output | 1 | Line request to memory (one cycle) |
| mem_line_o | output | 27 | Line address for memory |
| mem_first_o | output | 2 | Word index memory sends first |
| mem_rvalid_i | input | 1 | Memory beat valid |
| mem_rdata_i | input | 64 | Memory beat data |
| arr_we_o | output | 1 | Data array word write enable |
| arr_line_o | output | 27 | Line being written |
| arr_widx_o | output | 2 | Word index being written |
| arr_wdata_o | output | 64 | Word written |
| line_done_o | output | 1 | Line complete, may be marked valid |
| fwd_valid_o | output | 1 | Forwarded word valid, releases processor |
| fwd_data_o | output | 64 | Forwarded word |
| busy_o | output | 1 | Fill in progress |

## Verification
The bench targets misses on every word position in both modes. A wrong wrap computation would write beats to the wrong slots or forward the wrong word, and the beat check flags that by index. Random gaps between beats, and stray beats while idle, catch a counter that advances on idle cycles or on unsolicited data; such a counter would finish the line early or start the next fill mid-line. Misses injected during a fill catch a controller that re-latches its target or re-issues a request. Back-to-back fills check that the forward flag and the completion pulse rearm for each line and fire only once per line.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic {
    MODE_WRAP   = 1'b0,
    MODE_LINEAR = 1'b1
  } fill_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/lfc_beat_ctr.sv
module lfc_beat_ctr #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             beat_i,
  output logic [IDX_W-1:0] widx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] cnt_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      base_q <= base_i;
    end else if (beat_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-of-two line: index wraps naturally
  assign widx_o = base_q + cnt_q;
  assign last_o = (cnt_q == IDX_W'(WORDS - 1));

  assert_cnt_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_i && !start_i) |=> $stable(widx_o));
endmodule

// File: rtl/lfc_fwd.sv
module lfc_fwd #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  crit_i,
  input  logic              beat_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              fwd_valid_o,
  output logic [WORD_W-1:0] fwd_data_o,
  output logic              seen_o
);
  logic [IDX_W-1:0] crit_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_q <= '0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      crit_q <= crit_i;
      seen_q <= 1'b0;
    end else if (fwd_valid_o) begin
      seen_q <= 1'b1;
    end
  end

  assign fwd_valid_o = beat_i && (widx_i == crit_q) && !seen_q;
  assign fwd_data_o  = data_i;
  assign seen_o      = seen_q;

  assert_fwd_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> !fwd_valid_o);
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned LINE_BYTES = 32,
  localparam int unsigned WORDS     = LINE_BYTES / (WORD_W / 8),
  localparam int unsigned IDX_W     = $clog2(WORDS),
  localparam int unsigned BOFF_W    = $clog2(WORD_W / 8),
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              mode_i,
  output logic              miss_ready_o,
  output logic              mem_req_o,
  output logic [LINE_W-1:0] mem_line_o,
  output logic [IDX_W-1:0]  mem_first_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              arr_we_o,
  output logic [LINE_W-1:0] arr_line_o,
  output logic [IDX_W-1:0]  arr_widx_o,
  output logic [WORD_W-1:0] arr_wdata_o,
  output logic              line_done_o,
  output logic              fwd_valid_o,
  output logic [WORD_W-1:0] fwd_data_o,
  output logic              busy_o
);
  fill_state_e      state_q;
  logic [LINE_W-1:0] line_q;
  logic             accept, beat, last, fwd_seen;
  logic [IDX_W-1:0] crit_idx, first_idx, widx;

  assign crit_idx  = miss_addr_i[BOFF_W +: IDX_W];
  assign first_idx = (fill_mode_e'(mode_i) == MODE_WRAP) ? crit_idx : '0;
  assign accept    = (state_q == ST_IDLE) && miss_valid_i;
  assign beat      = (state_q == ST_FILL) && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
    end else begin
      if (accept) begin
        state_q <= ST_FILL;
        line_q  <= miss_addr_i[ADDR_W-1:OFF_W];
      end else if (beat && last) begin
        state_q <= ST_IDLE;
      end
    end
  end

  lfc_beat_ctr #(.WORDS(WORDS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .base_i  (first_idx),
    .beat_i  (beat),
    .widx_o  (widx),
    .last_o  (last)
  );

  lfc_fwd #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .crit_i      (crit_idx),
    .beat_i      (beat),
    .widx_i      (widx),
    .data_i      (mem_rdata_i),
    .fwd_valid_o (fwd_valid_o),
    .fwd_data_o  (fwd_data_o),
    .seen_o      (fwd_seen)
  );

  assign mem_req_o    = accept;
  assign mem_line_o   = miss_addr_i[ADDR_W-1:OFF_W];
  assign mem_first_o  = first_idx;
  assign arr_we_o     = beat;
  assign arr_line_o   = line_q;
  assign arr_widx_o   = widx;
  assign arr_wdata_o  = mem_rdata_i;
  assign line_done_o  = beat && last;
  assign busy_o       = (state_q == ST_FILL);
  assign miss_ready_o = !busy_o;

  assert_no_req_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_req_o);
  assert_we_in_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
  assert_busy_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !busy_o);
  assert_done_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (fwd_seen || fwd_valid_o));
  assert_done_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> arr_we_o);
  assert_req_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> busy_o);
endmodule

// File: tb/line_fill_ctrl_tb.sv
module line_fill_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0, mode_i = 1'b0;
  logic [31:0] miss_addr_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        miss_ready_o, mem_req_o, arr_we_o, line_done_o, fwd_valid_o, busy_o;
  logic [26:0] mem_line_o, arr_line_o;
  logic [1:0]  mem_first_o, arr_widx_o;
  logic [63:0] arr_wdata_o, fwd_data_o;

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fill_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
    .mode_i(mode_i), .miss_ready_o(miss_ready_o), .mem_req_o(mem_req_o),
    .mem_line_o(mem_line_o), .mem_first_o(mem_first_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .arr_we_o(arr_we_o), .arr_line_o(arr_line_o),
    .arr_widx_o(arr_widx_o), .arr_wdata_o(arr_wdata_o), .line_done_o(line_done_o),
    .fwd_valid_o(fwd_valid_o), .fwd_data_o(fwd_data_o), .busy_o(busy_o)
  );

  function automatic logic [63:0] beat_data(logic [26:0] line, logic [1:0] idx);
    return {5'd0, line, 28'hA5C3E17, 2'b00, idx};
  endfunction

  function automatic logic [1:0] exp_idx(bit mode, logic [1:0] crit, int k);
    return mode ? 2'(k) : 2'(crit + 2'(k));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one fill; gap_max idle cycles between beats; intrude drives stray misses in gaps
  task automatic run_fill(bit mode, logic [31:0] addr, int gap_max, bit intrude);
    logic [26:0] line = addr[31:5];
    logic [1:0]  crit = addr[4:3];
    int fwd_cnt = 0;
    @(negedge clk);
    miss_valid_i = 1'b1; miss_addr_i = addr; mode_i = mode;
    #1;
    check("R2 req", mem_req_o, 1);
    check("R2 line", mem_line_o, line);
    check("R2 first", mem_first_o, mode ? 2'd0 : crit);
    @(negedge clk);
    miss_valid_i = 1'b0;
    #1;
    check("R7 busy", busy_o, 1);
    check("R7 ready", miss_ready_o, 0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ei = exp_idx(mode, crit, k);
      int gap = (gap_max == 0) ? 0 : int'($urandom_range(gap_max));
      for (int g = 0; g < gap; g++) begin
        if (intrude) begin
          miss_valid_i = 1'b1; miss_addr_i = ~addr; mode_i = ~mode;
        end
        mem_rvalid_i = 1'b0; mem_rdata_i = 64'hDEAD;
        #1;
        check("R8 no req", mem_req_o, 0);
        check("R9 no we", {arr_we_o, fwd_valid_o, line_done_o}, 0);
        @(negedge clk);
      end
      miss_valid_i = intrude; miss_addr_i = ~addr; mode_i = ~mode;
      mem_rvalid_i = 1'b1; mem_rdata_i = beat_data(line, ei);
      #1;
      check("R11 we", arr_we_o, 1);
      check(mode ? "R4 order" : "R3 order", arr_widx_o, ei);
      check("R11 data", arr_wdata_o, beat_data(line, ei));
      check("R11 line", arr_line_o, line);
      check("R5 fwd", fwd_valid_o, ei == crit);
      if (fwd_valid_o) begin
        fwd_cnt++;
        check("R5 fwd data", fwd_data_o, beat_data(line, crit));
      end
      check("R6 done", line_done_o, k == 3);
      check("R7 busy hold", busy_o, 1);
      @(negedge clk);
    end
    mem_rvalid_i = 1'b0; miss_valid_i = 1'b0;
    #1;
    check("R5 count", fwd_cnt, 1);
    check("R7 busy low", busy_o, 0);
    check("R7 ready", miss_ready_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R1 busy", busy_o, 0);
    check("R1 outs", {mem_req_o, arr_we_o, fwd_valid_o, line_done_o}, 0);
    check("R1 ready", miss_ready_o, 1);
    #(CLK_PERIOD * 2);
    @(negedge clk) rst_ni = 1'b1;
    // directed: every critical position, both modes
    for (int c = 0; c < 4; c++) run_fill(1'b0, {27'h1234567, 2'(c), 3'b0}, 0, 1'b0);
    for (int c = 0; c < 4; c++) run_fill(1'b1, {27'h0ABCDEF, 2'(c), 3'b0}, 2, 1'b0);
    // stray beats while idle (R10)
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      mem_rvalid_i = 1'b1; mem_rdata_i = 64'hBAD0 + 64'(s);
      #1;
      check("R10 idle beat", {arr_we_o, fwd_valid_o, line_done_o, busy_o}, 0);
    end
    @(negedge clk) mem_rvalid_i = 1'b0;
    run_fill(1'b0, {27'h7000001, 2'd2, 3'b0}, 1, 1'b0); // R10 next fill starts clean
    run_fill(1'b1, {27'h7000002, 2'd3, 3'b0}, 3, 1'b1); // R8 intrusion
    run_fill(1'b0, {27'h7000003, 2'd1, 3'b0}, 3, 1'b1);
    // random
    for (int n = 0; n < 60; n++)
      run_fill(1'($urandom_range(1)), $urandom, int'($urandom_range(4)), 1'($urandom_range(1)));
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule